// File: doc/BRIEF.md
# Indirect Address Pointer Unit

This block keeps a small set of 12-bit data-memory pointers for a processor core. It applies the pointer-handling operations: adding or subtracting a short literal, loading a full 12-bit address from a two-word instruction, pushing a byte through the stack pointer, and forming stack-relative source and destination addresses for a memory-to-memory move. The core decodes the instruction class onto `op_i`, presents the first instruction word on `word0_i` and the second on `word1_i`, and raises `strobe_i` for one cycle per operation.

All results are registered. On the clock edge that samples the strobe, the pointer outputs take their new values, and exactly one of four one-cycle pulses reports what the core must do next:

- write a byte through `wr_addr_o` and `wr_data_o`;
- pop its return address;
- use the move addresses on `src_addr_o` and `dst_addr_o`;
- handle a malformed load.

The last pointer (index `NUM_PTR-1`) acts as the stack pointer. Memory itself and the return stack live outside this block.

Top module: `ptr_unit`

## Requirements
- R1: While `rst_ni` is low, every pointer reads zero and `wr_req_o`, `ret_o`, `addr_valid_o` and `err_o` are low.
- R2: Adjust (`op_i`=1) changes the pointer chosen by `word0_i[7:6]`. The operand is the zero-extended literal `word0_i[5:0]`. It adds when `word0_i[8]`=0 and subtracts when it is 1. The result wraps modulo 4096.
- R3: In adjust, a select value at or above the pointer count (3 by default) addresses the stack pointer (pointer 2).
- R4: Adjust-and-return (`op_i`=2) always applies the literal from R2 to the stack pointer, ignoring `word0_i[7:6]`, and pulses `ret_o` for one cycle.
- R5: Load (`op_i`=3) writes `{word0_i[3:0], word1_i[7:0]}` into the pointer selected by `word0_i[5:4]`.
- R6: A load whose `word1_i[15:8]` is not 0xF0, or whose select is 3, changes no pointer and pulses `err_o`.
- R7: Push (`op_i`=4) pulses `wr_req_o`, with `wr_addr_o` set to the old stack pointer and `wr_data_o` set to `word0_i[7:0]`. The stack pointer then decrements, so 0 becomes 0xFFF.
- R8: Move (`op_i`=5) pulses `addr_valid_o` and changes no pointer. `src_addr_o` is (stack pointer + `word0_i[6:0]`) mod 4096. `dst_addr_o` is (stack pointer + `word1_i[6:0]`) mod 4096 when `word0_i[7]`=1, and `word1_i[11:0]` otherwise.
- R9: With `strobe_i` low, or with `op_i` equal to 0, 6 or 7, no pointer changes and no pulse is raised.
- R10: Each result appears on the clock edge that samples the strobe. At most one of the four pulses is high at a time, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One operation per high cycle |
| op_i | input | 3 | Operation class (see requirements) |
| word0_i | input | 16 | First instruction word |
| word1_i | input | 16 | Second instruction word |
| ptrs_o | output | NUM_PTR*PTR_W (36) | All pointers, pointer 0 in the low bits |
| wr_req_o | output | 1 | Push write request pulse |
| wr_addr_o | output | PTR_W (12) | Push write address |
| wr_data_o | output | DATA_W (8) | Push write data |
| ret_o | output | 1 | Return request pulse |
| addr_valid_o | output | 1 | Move addresses valid pulse |
| src_addr_o | output | PTR_W (12) | Move source address |
| dst_addr_o | output | PTR_W (12) | Move destination address |
| err_o | output | 1 | Malformed load pulse |

## Verification
The assertions assume that `op_i`, `word0_i` and `word1_i` are stable at the edge where `strobe_i` is sampled. They treat each strobe as a single independent operation. The stimulus drives every input on the falling edge and holds it through the next rising edge. It drops the strobe for a cycle after each operation, so every pulse can be seen to fall and the pointers can be seen to hold. The bench also runs the table as one chained program, so wraparound cases are reached from pointer values that earlier operations left behind.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  localparam int PW = 12;

  localparam logic [2:0] OP_NONE    = 3'd0;
  localparam logic [2:0] OP_ADJ     = 3'd1;
  localparam logic [2:0] OP_ADJ_RET = 3'd2;
  localparam logic [2:0] OP_LOAD    = 3'd3;
  localparam logic [2:0] OP_PUSH    = 3'd4;
  localparam logic [2:0] OP_MOVE    = 3'd5;

  typedef struct packed {
    logic          upd;
    logic [1:0]    idx;
    logic          load;
    logic          sub;
    logic [PW-1:0] opnd;
    logic          push;
    logic          ret;
    logic          move;
    logic          err;
  } dec_t;
endpackage

// File: rtl/ptr_decode.sv
module ptr_decode
  import ptr_pkg::*;
#(
  parameter int NUM_PTR = 3,
  parameter int LIT_W   = 6
) (
  input  logic        strobe_i,
  input  logic [2:0]  op_i,
  input  logic [15:0] word0_i,
  input  logic [15:0] word1_i,
  output dec_t        dec_o
);
  localparam logic [1:0] SP_IDX = 2'(NUM_PTR - 1);
  localparam logic [7:0] W1_TAG = 8'hF0;

  logic [1:0] adj_sel, ld_sel;
  logic       unused_bits;

  assign adj_sel = (word0_i[7:6] >= 2'(NUM_PTR)) ? SP_IDX : word0_i[7:6];
  assign ld_sel  = word0_i[5:4];
  assign unused_bits = ^{word0_i[15:9], word1_i[15:8]};

  always_comb begin
    dec_o = '0;
    if (strobe_i) begin
      unique case (op_i)
        OP_ADJ: begin
          dec_o.upd  = 1'b1;
          dec_o.idx  = adj_sel;
          dec_o.sub  = word0_i[8];
          dec_o.opnd = PW'(word0_i[LIT_W-1:0]);
        end
        OP_ADJ_RET: begin
          dec_o.upd  = 1'b1;
          dec_o.idx  = SP_IDX;
          dec_o.sub  = word0_i[8];
          dec_o.opnd = PW'(word0_i[LIT_W-1:0]);
          dec_o.ret  = 1'b1;
        end
        OP_LOAD: begin
          if (word1_i[15:8] != W1_TAG || ld_sel >= 2'(NUM_PTR)) begin
            dec_o.err = 1'b1;
          end else begin
            dec_o.upd  = 1'b1;
            dec_o.load = 1'b1;
            dec_o.idx  = ld_sel;
            dec_o.opnd = {word0_i[3:0], word1_i[7:0]};
          end
        end
        OP_PUSH: begin
          dec_o.upd  = 1'b1;
          dec_o.idx  = SP_IDX;
          dec_o.sub  = 1'b1;
          dec_o.opnd = PW'(1);
          dec_o.push = 1'b1;
        end
        OP_MOVE: dec_o.move = 1'b1;
        default: dec_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ptr_alu.sv
module ptr_alu #(
  parameter int PTR_W = 12,
  parameter int OFS_W = 7
) (
  input  logic [PTR_W-1:0] cur_i,
  input  logic [PTR_W-1:0] opnd_i,
  input  logic             sub_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] sp_i,
  input  logic [15:0]      word0_i,
  input  logic [15:0]      word1_i,
  output logic [PTR_W-1:0] nxt_o,
  output logic [PTR_W-1:0] src_o,
  output logic [PTR_W-1:0] dst_o
);
  logic unused_bits;
  assign unused_bits = ^{word0_i[15:8], word1_i[15:PTR_W]};

  always_comb begin
    if (load_i)     nxt_o = opnd_i;
    else if (sub_i) nxt_o = cur_i - opnd_i;
    else            nxt_o = cur_i + opnd_i;
  end

  // stack-relative move addresses, wrap at pointer width
  assign src_o = sp_i + PTR_W'(word0_i[OFS_W-1:0]);
  assign dst_o = word0_i[OFS_W] ? sp_i + PTR_W'(word1_i[OFS_W-1:0])
                                : word1_i[PTR_W-1:0];
endmodule

// File: rtl/ptr_bank.sv
module ptr_bank #(
  parameter int NUM_PTR = 3,
  parameter int PTR_W   = 12
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [1:0]                      idx_i,
  input  logic [PTR_W-1:0]                wdata_i,
  output logic [NUM_PTR-1:0][PTR_W-1:0]   ptr_o
);
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         ptr_o[i] <= '0;
      else if (we_i && idx_i == 2'(i))     ptr_o[i] <= wdata_i;
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ptr_o));
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit
  import ptr_pkg::*;
#(
  parameter int NUM_PTR = 3,
  parameter int PTR_W   = 12,
  parameter int LIT_W   = 6,
  parameter int OFS_W   = 7,
  parameter int DATA_W  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     strobe_i,
  input  logic [2:0]               op_i,
  input  logic [15:0]              word0_i,
  input  logic [15:0]              word1_i,
  output logic [NUM_PTR*PTR_W-1:0] ptrs_o,
  output logic                     wr_req_o,
  output logic [PTR_W-1:0]         wr_addr_o,
  output logic [DATA_W-1:0]        wr_data_o,
  output logic                     ret_o,
  output logic                     addr_valid_o,
  output logic [PTR_W-1:0]         src_addr_o,
  output logic [PTR_W-1:0]         dst_addr_o,
  output logic                     err_o
);
  localparam int SP = NUM_PTR - 1;

  dec_t                          dec;
  logic [NUM_PTR-1:0][PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0]              cur, nxt, src_c, dst_c, sp;

  ptr_decode #(.NUM_PTR(NUM_PTR), .LIT_W(LIT_W)) u_dec (
    .strobe_i(strobe_i), .op_i(op_i), .word0_i(word0_i),
    .word1_i(word1_i), .dec_o(dec)
  );

  assign sp  = ptr_q[SP];
  assign cur = ptr_q[dec.idx];

  ptr_alu #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_alu (
    .cur_i(cur), .opnd_i(dec.opnd), .sub_i(dec.sub), .load_i(dec.load),
    .sp_i(sp), .word0_i(word0_i), .word1_i(word1_i),
    .nxt_o(nxt), .src_o(src_c), .dst_o(dst_c)
  );

  ptr_bank #(.NUM_PTR(NUM_PTR), .PTR_W(PTR_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(dec.upd), .idx_i(dec.idx),
    .wdata_i(nxt), .ptr_o(ptr_q)
  );

  assign ptrs_o = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_req_o     <= 1'b0;
      ret_o        <= 1'b0;
      addr_valid_o <= 1'b0;
      err_o        <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      src_addr_o   <= '0;
      dst_addr_o   <= '0;
    end else begin
      wr_req_o     <= dec.push;
      ret_o        <= dec.ret;
      addr_valid_o <= dec.move;
      err_o        <= dec.err;
      if (dec.push) begin
        wr_addr_o <= sp;
        wr_data_o <= word0_i[DATA_W-1:0];
      end
      if (dec.move) begin
        src_addr_o <= src_c;
        dst_addr_o <= dst_c;
      end
    end
  end

  // R10
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_req_o, ret_o, addr_valid_o, err_o}));

  // R7
  push_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && op_i == OP_PUSH |=>
      wr_req_o && wr_addr_o == $past(ptrs_o[SP*PTR_W +: PTR_W]) &&
      ptrs_o[SP*PTR_W +: PTR_W] == PTR_W'($past(ptrs_o[SP*PTR_W +: PTR_W]) - PTR_W'(1)));

  // R4
  ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && op_i == OP_ADJ_RET |=> ret_o);

  // R6
  load_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && op_i == OP_LOAD && word1_i[15:8] != 8'hF0 |=> err_o && $stable(ptrs_o));

  // R8
  move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && op_i == OP_MOVE |=> addr_valid_o && $stable(ptrs_o) &&
      src_addr_o == PTR_W'($past(ptrs_o[SP*PTR_W +: PTR_W]) + PTR_W'($past(word0_i[OFS_W-1:0]))));
endmodule

// File: tb/sim_ptr_unit.sv
module sim_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] w0 = '0, w1 = '0;
  logic [35:0] ptrs;
  logic        wr_req, ret, av, err;
  logic [11:0] wr_addr, src, dst;
  logic [7:0]  wr_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ptr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .op_i(op),
    .word0_i(w0), .word1_i(w1), .ptrs_o(ptrs), .wr_req_o(wr_req),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .ret_o(ret),
    .addr_valid_o(av), .src_addr_o(src), .dst_addr_o(dst), .err_o(err)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] w0;
    logic [15:0] w1;
    logic [11:0] p0, p1, p2;
    logic [3:0]  fl;   // {wr, ret, av, err}
    logic [11:0] a;    // wr_addr or src
    logic [11:0] b;    // wr_data or dst
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 16'h0005, 16'h0000, 12'h005, 12'h000, 12'h000, 4'h0, 12'h000, 12'h000}, // R2 add
    '{3'd1, 16'h0141, 16'h0000, 12'h005, 12'hFFF, 12'h000, 4'h0, 12'h000, 12'h000}, // R2 sub wrap
    '{3'd1, 16'h00FF, 16'h0000, 12'h005, 12'hFFF, 12'h03F, 4'h0, 12'h000, 12'h000}, // R3 alias
    '{3'd2, 16'h0150, 16'h0000, 12'h005, 12'hFFF, 12'h02F, 4'h4, 12'h000, 12'h000}, // R4
    '{3'd3, 16'h000A, 16'hF0C3, 12'hAC3, 12'hFFF, 12'h02F, 4'h0, 12'h000, 12'h000}, // R5
    '{3'd3, 16'h0017, 16'hF012, 12'hAC3, 12'h712, 12'h02F, 4'h0, 12'h000, 12'h000}, // R5
    '{3'd3, 16'h0025, 16'hF112, 12'hAC3, 12'h712, 12'h02F, 4'h1, 12'h000, 12'h000}, // R6 tag
    '{3'd3, 16'h0031, 16'hF055, 12'hAC3, 12'h712, 12'h02F, 4'h1, 12'h000, 12'h000}, // R6 sel3
    '{3'd4, 16'h00A5, 16'h0000, 12'hAC3, 12'h712, 12'h02E, 4'h8, 12'h02F, 12'h0A5}, // R7
    '{3'd5, 16'h00FF, 16'hF001, 12'hAC3, 12'h712, 12'h02E, 4'h2, 12'h0AD, 12'h02F}, // R8 rel
    '{3'd5, 16'h0003, 16'hF9AB, 12'hAC3, 12'h712, 12'h02E, 4'h2, 12'h031, 12'h9AB}, // R8 abs
    '{3'd0, 16'h0FFF, 16'hFFFF, 12'hAC3, 12'h712, 12'h02E, 4'h0, 12'h000, 12'h000}, // R9
    '{3'd7, 16'h0005, 16'hF0FF, 12'hAC3, 12'h712, 12'h02E, 4'h0, 12'h000, 12'h000}, // R9
    '{3'd3, 16'h002F, 16'hF0FF, 12'hAC3, 12'h712, 12'hFFF, 4'h0, 12'h000, 12'h000}, // R5
    '{3'd5, 16'h00FF, 16'hF07F, 12'hAC3, 12'h712, 12'hFFF, 4'h2, 12'h07E, 12'h07E}, // R8 wrap
    '{3'd1, 16'h0081, 16'h0000, 12'hAC3, 12'h712, 12'h000, 4'h0, 12'h000, 12'h000}, // R2 add wrap
    '{3'd4, 16'h003C, 16'h0000, 12'hAC3, 12'h712, 12'hFFF, 4'h8, 12'h000, 12'h03C}, // R7 wrap
    '{3'd2, 16'h0001, 16'h0000, 12'hAC3, 12'h712, 12'h000, 4'h4, 12'h000, 12'h000}  // R4 add
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 ptrs", ptrs, '0);
    chk("R1 pulses", {32'd0, wr_req, ret, av, err}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      op = VEC[i].op; w0 = VEC[i].w0; w1 = VEC[i].w1; strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
      chk($sformatf("R2-step%0d ptrs", i), ptrs, {VEC[i].p2, VEC[i].p1, VEC[i].p0});
      chk($sformatf("R10 flags step%0d", i), {32'd0, wr_req, ret, av, err}, {32'd0, VEC[i].fl});
      if (VEC[i].fl[3]) begin
        chk("R7 wr_addr", {24'd0, wr_addr}, {24'd0, VEC[i].a});
        chk("R7 wr_data", {28'd0, wr_data}, {24'd0, VEC[i].b});
      end
      if (VEC[i].fl[1]) begin
        chk("R8 src", {24'd0, src}, {24'd0, VEC[i].a});
        chk("R8 dst", {24'd0, dst}, {24'd0, VEC[i].b});
      end
      @(negedge clk);
      chk("R10 pulse one cycle", {32'd0, wr_req, ret, av, err}, '0);
      chk("R9 hold idle", ptrs, {VEC[i].p2, VEC[i].p1, VEC[i].p0});
    end

    // R9 operation presented without strobe
    op = 3'd1; w0 = 16'h0005; strobe = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 no strobe", ptrs, {12'h000, 12'h712, 12'hAC3});
    op = 3'd4;
    @(negedge clk);
    chk("R9 no strobe push", {35'd0, wr_req}, '0);

    // R1 mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset", ptrs, '0);
    chk("R1 mid reset pulses", {32'd0, wr_req, ret, av, err}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end
endmodule